// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block lets synchronous logic perform single byte reads and writes on an asynchronous static RAM that shares one bidirectional data pin group. A request enters on a valid/ready handshake carrying an address, a write flag and write data. The controller then runs a fixed three-cycle strobe sequence on the active-low chip select, write enable and output enable pins. A read returns its byte with a one-cycle response pulse.

Three groups of flip-flops sit at the pin boundary so that each can be placed in an I/O cell: outbound data, the per-bit drive enable, and the inbound sample of the pins. The drive enable is itself registered rather than decoded. This costs one cycle in each direction, but every pin toggles straight off a clock edge.

Back-pressure rules: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. While a transfer is in progress, `req_ready` stays low and the request inputs are ignored. The response side has no ready input: the consumer must accept `rsp_rdata` in the cycle that `rsp_valid` is high.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After synchronous reset, and in every idle cycle, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are high, the controller does not drive `mem_dq`, `rsp_valid` is low and `req_ready` is high.
- R2: An accepted write occupies the three cycles after the accepting edge. `mem_cs_n` is low in all three, `mem_oe_n` is high in all three, `mem_we_n` is low only in the second, and the write byte is driven on `mem_dq` in all three.
- R3: An accepted read occupies the three cycles after the accepting edge. `mem_cs_n` and `mem_oe_n` are low in the first two and high in the third, `mem_we_n` stays high, and the controller never drives `mem_dq`.
- R4: In the third cycle of a read, `rsp_valid` is high for exactly one cycle and `rsp_rdata` equals the value present on `mem_dq` at the end of the second cycle.
- R5: `req_ready` is high only in idle cycles, so at least one idle cycle with all strobes high separates any two transfers.
- R6: Changes to `req_valid`, `req_write`, `req_addr` and `req_wdata` during a transfer do not affect that transfer's address, data or strobes, and do not start a new one.
- R7: `mem_we_n` and `mem_oe_n` are never low together, and the controller drives `mem_dq` only while `mem_oe_n` is high.
- R8: Asserting `rst` in the middle of a transfer abandons it. From the next cycle the pins are in the idle state of R1 and no response pulse follows.
- R9: `mem_addr` is set on the accepting edge and stays unchanged until the next accepted request. In the write hold cycle, both address and data are the same as in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Read byte, meaningful while `rsp_valid` is high |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq | inout | DATA_W | Shared data pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the controller with `ADDR_W` = 10 and the default `DATA_W` = 8. A 1024-entry behavioural memory on the shared pins can then cover every address, including both ends of the range. Because that memory drives the pins only when chip select and output enable are both low, each read-back byte it returns tests the registered drive enable and the input sample. The narrow address also keeps the run well inside the cycle budget while covering back-to-back requests, requests held across busy periods, and a reset that lands inside a read.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_STROBE,
    ST_WR_HOLD,
    ST_RD_OPEN,
    ST_RD_CAPTURE,
    ST_RD_DONE
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  function automatic strobe_t strobes_for(phase_e p);
    strobe_t s;
    s = STROBE_IDLE;
    case (p)
      ST_WR_SETUP, ST_WR_HOLD: begin
        s.cs_n  = 1'b0;
        s.drive = 1'b1;
      end
      ST_WR_STROBE: begin
        s.cs_n  = 1'b0;
        s.we_n  = 1'b0;
        s.drive = 1'b1;
      end
      ST_RD_OPEN, ST_RD_CAPTURE: begin
        s.cs_n = 1'b0;
        s.oe_n = 1'b0;
      end
      default: s = STROBE_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_bus_seq.sv
module sram_bus_seq
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              accept,
  output logic              drive_d,
  output strobe_t           strb_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rsp_valid_q
);

  phase_e phase_q, phase_d;
  strobe_t strb_d;

  assign req_ready = (phase_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      ST_IDLE:       if (accept) phase_d = req_write ? ST_WR_SETUP : ST_RD_OPEN;
      ST_WR_SETUP:   phase_d = ST_WR_STROBE;
      ST_WR_STROBE:  phase_d = ST_WR_HOLD;
      ST_WR_HOLD:    phase_d = ST_IDLE;
      ST_RD_OPEN:    phase_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: phase_d = ST_RD_DONE;
      ST_RD_DONE:    phase_d = ST_IDLE;
      default:       phase_d = ST_IDLE;
    endcase
  end

  assign strb_d  = strobes_for(phase_d);
  assign drive_d = strb_d.drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= ST_IDLE;
      strb_q      <= STROBE_IDLE;
      rsp_valid_q <= 1'b0;
      addr_q      <= '0;
    end else begin
      phase_q     <= phase_d;
      strb_q      <= strb_d;
      rsp_valid_q <= (phase_d == ST_RD_DONE);
      if (accept) addr_q <= req_addr;
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!strb_q.we_n && !strb_q.oe_n)); // R7

  AST_WE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    !strb_q.we_n |-> !strb_q.cs_n); // R2

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |=> !rsp_valid_q); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(addr_q)); // R6

endmodule

// File: rtl/sram_bus_io.sv
module sram_bus_io #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_d,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic [DATA_W-1:0] din_q
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        dq_out[b] <= 1'b0;
        dq_oe[b]  <= 1'b0;
        din_q[b]  <= 1'b0;
      end else begin
        if (load) dq_out[b] <= wdata[b];
        dq_oe[b] <= drive_d;
        din_q[b] <= dq_in[b];
      end
    end
  end

  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == '0) || (dq_oe == '1)); // R7

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  logic              accept;
  logic              drive_d;
  strobe_t           strb_q;
  logic [DATA_W-1:0] dq_out, dq_oe, din_q;

  sram_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .accept     (accept),
    .drive_d    (drive_d),
    .strb_q     (strb_q),
    .addr_q     (mem_addr),
    .rsp_valid_q(rsp_valid)
  );

  sram_bus_io #(.DATA_W(DATA_W)) u_io (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .wdata  (req_wdata),
    .drive_d(drive_d),
    .dq_in  (mem_dq),
    .dq_out (dq_out),
    .dq_oe  (dq_oe),
    .din_q  (din_q)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_pad
    assign mem_dq[b] = dq_oe[b] ? dq_out[b] : 1'bz;
  end

  assign mem_cs_n  = strb_q.cs_n;
  assign mem_we_n  = strb_q.we_n;
  assign mem_oe_n  = strb_q.oe_n;
  assign rsp_rdata = din_q;

  AST_NO_DRIVE_OE_LOW: assert property (@(posedge clk) disable iff (rst)
    (|dq_oe) |-> mem_oe_n); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !(|dq_oe))); // R1

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $rose(mem_we_n)) |-> ($stable(mem_addr) && $stable(dq_out) && (&dq_oe))); // R9

endmodule

// File: tb/sram_bus_ctrl_test.sv
`timescale 1ns/1ps
module sram_bus_ctrl_test;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  // behavioural memory on the shared pins
  logic [DW-1:0] sram [DEPTH];
  assign mem_dq = (!mem_cs_n && !mem_oe_n && mem_we_n) ? sram[mem_addr] : 'z;

  initial for (int i = 0; i < DEPTH; i++) sram[i] = 8'((i * 37 + 11) ^ (i >> 3));

  // reference model: phase 0 idle, 1..3 transfer cycles
  int            m_phase = 0;
  bit            m_wr = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  logic [DW-1:0] m_rd_exp = '0;
  bit            started = 1'b0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) m_phase = 0;
    else if (m_phase == 0) begin
      if (req_valid) begin
        m_phase = 1; m_wr = req_write; m_addr = req_addr; m_data = req_wdata;
      end
    end else if (m_phase == 3) m_phase = 0;
    else m_phase = m_phase + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      bit e_cs, e_we, e_oe;
      e_cs = !(m_phase != 0 && (m_wr || m_phase < 3));
      e_we = !(m_wr && m_phase == 2);
      e_oe = !(!m_wr && (m_phase == 1 || m_phase == 2));
      check(req_ready == (m_phase == 0), "R5 ready", int'(req_ready), int'(m_phase == 0));
      check(mem_cs_n == e_cs, m_wr ? "R2 cs_n" : "R3 cs_n", int'(mem_cs_n), int'(e_cs));
      check(mem_we_n == e_we, m_wr ? "R2 we_n" : "R3 we_n", int'(mem_we_n), int'(e_we));
      check(mem_oe_n == e_oe, m_wr ? "R2 oe_n" : "R3 oe_n", int'(mem_oe_n), int'(e_oe));
      check(rsp_valid == (!m_wr && m_phase == 3), "R4 rsp_valid", int'(rsp_valid), int'(!m_wr && m_phase == 3));
      if (m_phase == 0) check(rsp_valid == 1'b0 && mem_cs_n, "R1 idle pins", int'(mem_cs_n), 1);
      if (m_phase != 0) check(mem_addr == m_addr, "R9 addr held", int'(mem_addr), int'(m_addr));
      if (m_wr && m_phase != 0 && !rst)
        check(mem_dq === m_data, "R2 write data on bus", int'(mem_dq), int'(m_data));
      if (!m_wr && m_phase == 2) m_rd_exp = sram[m_addr];
      if (!m_wr && m_phase == 3)
        check(rsp_rdata == m_rd_exp, "R4 read data", int'(rsp_rdata), int'(m_rd_exp));
      if (!mem_cs_n && !mem_we_n) sram[mem_addr] = mem_dq;
    end
  end

  task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input int linger);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // R6: scramble request inputs while busy
    req_write = !w; req_addr = ~a; req_wdata = ~d;
    for (int k = 0; k < linger; k++) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && mem_cs_n && mem_we_n && mem_oe_n && !rsp_valid, "R1 reset state",
          int'({req_ready, mem_cs_n, mem_we_n, mem_oe_n, rsp_valid}), 5'b11110);
    rst = 1'b0;
    idle(2);
    do_req(1'b1, 10'h000, 8'hA5, 0);
    do_req(1'b1, 10'h3FF, 8'h5A, 0);
    do_req(1'b0, 10'h000, 8'h00, 0);
    do_req(1'b0, 10'h3FF, 8'h00, 0);
    do_req(1'b0, 10'h155, 8'h00, 2);   // R6 valid held with junk while busy
    do_req(1'b1, 10'h155, 8'hC3, 2);
    do_req(1'b0, 10'h155, 8'h00, 0);
    for (int i = 0; i < 40; i++) begin
      do_req(i[0], AW'(i * 29 + 3), DW'(i * 13 + 7), i % 3);
      if (i % 4 == 0) idle(1);
    end
    // R8 reset in the middle of a read
    do_req(1'b0, 10'h0F0, 8'h00, 0);
    rst = 1'b1;
    idle(2);
    check(mem_cs_n && mem_oe_n && !rsp_valid && req_ready, "R8 abort on reset",
          int'({mem_cs_n, mem_oe_n, rsp_valid, req_ready}), 4'b1101);
    rst = 1'b0;
    idle(3);
    do_req(1'b0, 10'h3FF, 8'h00, 0);
    idle(6);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule